// File: doc/BRIEF.md
# Registered Two-Bus Transceiver

This block joins two 8-bit buses, A and B. Each direction of travel owns a storage register, and each register has its own capture strobe. A per-direction select picks what the far bus receives: either the live value from the near bus or the value held in that direction's register. An active-low enable and a direction input then decide which bus, if either, is driven.

Bidirectional pads are split into an input vector, an output vector and an output-enable vector for each bus, so the whole block stays synthesizable. The capture strobes are treated as slow inputs synchronous to the system clock `clk_i`. A rising-edge detector on each strobe turns a low-to-high transition into a one-cycle load of the register.

Register loads never depend on the enable or the direction. Data can therefore be parked in a register while both buses are isolated, and driven out later.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `rst_ni` is low, both storage registers are cleared to zero. In stored mode both data outputs read 0x00 after reset.
- R2: With `en_ni` high, `a_oe_o` and `b_oe_o` are both 0x00 (isolation).
- R3: With `en_ni` low and `dir_i` high, `b_oe_o` is 0xFF and `a_oe_o` is 0x00. With `en_ni` low and `dir_i` low, `a_oe_o` is 0xFF and `b_oe_o` is 0x00.
- R4: With `sel_ab_i` low, `b_o` equals the live `a_i` in the same cycle.
- R5: With `sel_ab_i` high, `b_o` equals the A-side register.
- R6: With `sel_ba_i` low, `a_o` equals the live `b_i`. With it high, `a_o` equals the B-side register.
- R7: At a `clk_i` edge where `clk_ab_i` (resp. `clk_ba_i`) is high and was low at the previous edge, the A-side (B-side) register loads `a_i` (`b_i`). The new value appears on the stored-mode output right after that edge. At every other edge the register holds.
- R8: Register loads happen whatever the values of `en_ni` and `dir_i`, including during isolation.
- R9: `a_oe_o` and `b_oe_o` are never nonzero in the same cycle.
- R10: `a_o` and `b_o` always present the selected value, whether or not their output enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_ni | input | 1 | Active-low output enable |
| dir_i | input | 1 | 1: drive B from A side, 0: drive A from B side |
| sel_ab_i | input | 1 | B output source: 0 live A, 1 A-side register |
| sel_ba_i | input | 1 | A output source: 0 live B, 1 B-side register |
| clk_ab_i | input | 1 | Capture strobe for the A-side register |
| clk_ba_i | input | 1 | Capture strobe for the B-side register |
| a_i | input | 8 | Bus A pad input |
| a_o | output | 8 | Bus A pad output value |
| a_oe_o | output | 8 | Bus A pad output enable |
| b_i | input | 8 | Bus B pad input |
| b_o | output | 8 | Bus B pad output value |
| b_oe_o | output | 8 | Bus B pad output enable |

## Verification
The assertions assume that the capture strobes and bus inputs are synchronous to `clk_i`, and that each strobe level lasts at least one system cycle. A strobe shorter than that would be missed by the edge detector. The stimulus changes every input only on the falling edge of `clk_i`, and holds each strobe level for at least one full cycle. Strobes rise during every enable/direction/select combination, isolation included, so stored values taken while the buses are isolated are later read out.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_W = 8;
  localparam int unsigned XCVR_LANES = 2;  // lane 0: A to B, lane 1: B to A
  typedef logic [XCVR_W-1:0] xcvr_word_t;
endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= raw_i;

  assign rise_o = raw_i & ~prev_q;

  // a rise cannot repeat on the next cycle
  assert_single_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    q_o <= '0;
    else if (cap_i) q_o <= d_i;

  assert_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> q_o == $past(d_i));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(q_o));
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_ni,
  input  logic         active_i,
  input  logic         sel_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] stored_i,
  output logic [W-1:0] data_o,
  output logic [W-1:0] oe_o
);
  assign data_o = sel_i ? stored_i : live_i;
  assign oe_o   = {W{~en_ni & active_i}};

  assert_oe_uniform_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o == '0) || (oe_o == '1));
  assert_isolate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_ni |-> oe_o == '0);
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_ni,
  input  logic       dir_i,
  input  logic       sel_ab_i,
  input  logic       sel_ba_i,
  input  logic       clk_ab_i,
  input  logic       clk_ba_i,
  input  logic [7:0] a_i,
  output logic [7:0] a_o,
  output logic [7:0] a_oe_o,
  input  logic [7:0] b_i,
  output logic [7:0] b_o,
  output logic [7:0] b_oe_o
);
  xcvr_word_t [XCVR_LANES-1:0] src, dst, oe, held;
  logic       [XCVR_LANES-1:0] strobe, sel, active, cap;

  assign src    = {b_i, a_i};
  assign strobe = {clk_ba_i, clk_ab_i};
  assign sel    = {sel_ba_i, sel_ab_i};
  assign active = {~dir_i, dir_i};

  for (genvar l = 0; l < XCVR_LANES; l++) begin : g_lane
    xcvr_edge i_edge (
      .clk_i, .rst_ni, .raw_i(strobe[l]), .rise_o(cap[l])
    );
    xcvr_store #(.W(XCVR_W)) i_store (
      .clk_i, .rst_ni, .cap_i(cap[l]), .d_i(src[l]), .q_o(held[l])
    );
    xcvr_drive #(.W(XCVR_W)) i_drive (
      .clk_i, .rst_ni, .en_ni, .active_i(active[l]), .sel_i(sel[l]),
      .live_i(src[l]), .stored_i(held[l]), .data_o(dst[l]), .oe_o(oe[l])
    );
  end

  assign b_o    = dst[0];
  assign b_oe_o = oe[0];
  assign a_o    = dst[1];
  assign a_oe_o = oe[1];

  assert_one_side_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|a_oe_o) && (|b_oe_o)));
  // live path follows the opposite bus in the same cycle
  assert_live_ab_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_ab_i |-> b_o == a_i);
endmodule

// File: tb/test_bus_xcvr_reg.sv
`timescale 1ns/1ps
module test_bus_xcvr_reg;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en_n = 1'b1, dir = 1'b0, sel_ab = 1'b1, sel_ba = 1'b1;
  logic cab = 1'b0, cba = 1'b0;
  logic [7:0] a_in = '0, b_in = '0;
  logic [7:0] a_out, a_oe, b_out, b_oe;
  int checks = 0, errors = 0;

  // behavioural reference
  logic [7:0] m_rega = '0, m_regb = '0;
  logic m_pab = 1'b0, m_pba = 1'b0;

  always #2.5 clk = ~clk;

  bus_xcvr_reg i_bus_xcvr_reg (
    .clk_i(clk), .rst_ni(rst_n), .en_ni(en_n), .dir_i(dir),
    .sel_ab_i(sel_ab), .sel_ba_i(sel_ba), .clk_ab_i(cab), .clk_ba_i(cba),
    .a_i(a_in), .a_o(a_out), .a_oe_o(a_oe),
    .b_i(b_in), .b_o(b_out), .b_oe_o(b_oe)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rega = '0; m_regb = '0; m_pab = 1'b0; m_pba = 1'b0;
    end else begin
      if (cab && !m_pab) m_rega = a_in;
      if (cba && !m_pba) m_regb = b_in;
      m_pab = cab; m_pba = cba;
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // full comparison against the reference, done at the falling edge
  task automatic compare_all();
    logic [7:0] eb, ea;
    eb = sel_ab ? m_rega : a_in;
    ea = sel_ba ? m_regb : b_in;
    check(sel_ab ? "R5 b_o stored" : "R4 b_o live", b_out, eb);
    check(sel_ba ? "R6 a_o stored" : "R6 a_o live", a_out, ea);
    if (en_n) begin
      check("R2 a_oe", a_oe, 8'h00);
      check("R2 b_oe", b_oe, 8'h00);
    end else begin
      check("R3 a_oe", a_oe, dir ? 8'h00 : 8'hFF);
      check("R3 b_oe", b_oe, dir ? 8'hFF : 8'h00);
    end
    check("R9 exclusive", ((|a_oe) && (|b_oe)) ? 8'h01 : 8'h00, 8'h00);
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: registers are zero after reset, seen through stored mode
    check("R1 a_o reset", a_out, 8'h00);
    check("R1 b_o reset", b_out, 8'h00);
    rst_n = 1'b1;
    a_in = 8'h5A; b_in = 8'hC3;
    step();
    check("R1 b_o after release", b_out, 8'h00);

    // R8: load during isolation, then R7 read out after the strobe edge
    en_n = 1'b1; cab = 1'b1; cba = 1'b1;
    step();
    check("R8 A load isolated", b_out, 8'h5A);
    check("R8 B load isolated", a_out, 8'hC3);
    // strobe held high: no further load (R7)
    a_in = 8'h11; b_in = 8'h22;
    step();
    check("R7 hold while high", b_out, 8'h5A);
    check("R7 hold while high B", a_out, 8'hC3);
    cab = 1'b0; cba = 1'b0;
    step();
    check("R7 falling edge no load", b_out, 8'h5A);

    // R10: output value present with enables off
    sel_ab = 1'b0;
    step();
    check("R10 value while isolated", b_out, 8'h11);
    check("R4 live A to B", b_out, a_in);

    // all enable/direction/select combinations, random data and strobes
    for (int r = 0; r < 40; r++) begin
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        {en_n, dir, sel_ab, sel_ba} = 4'(c);
        a_in = 8'($urandom); b_in = 8'($urandom);
        cab = 1'($urandom); cba = 1'($urandom);
        step();
      end
    end

    // R8: load with enable low and direction pointing the other way
    @(negedge clk);
    cab = 1'b0; en_n = 1'b0; dir = 1'b0; sel_ab = 1'b1;
    step();
    a_in = 8'hE7; cab = 1'b1;
    step();
    check("R8 load while A is driven", b_out, 8'hE7);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule